// File: doc/BRIEF.md
# Configuration Stream Integrity Checker

This block watches the 32-bit words written into a switch's static configuration area, which begins at word address 20000h. The words arrive one per accepted cycle, with a valid flag and a flag marking the first word of a load. A load may come in one burst or in several bursts with idle cycles between them. The first word must equal a device identifier fixed by a parameter. Configuration blocks follow it. Each block has two header words, a CRC over the header, the payload words and a CRC over the payload. The load ends with a terminating header whose length field is zero, followed by a CRC over every word that came before it.

Each payload word is passed on to table writers through a one-cycle strobe, together with its block number and its data. Table writers must discard what they received if the load later fails. The completion flag rises only when every check has passed. If any check fails, an error code reports which check it was. All later words are then ignored until a new first word arrives.

Top module: `cfgchk_top`

## Requirements
- R1: After reset, `cfg_done` is 0, `err_code` is 0 and `wr_valid` is 0.
- R2: A word accepted with `in_start` high restarts the check and clears `cfg_done`. If the word differs from `DEV_ID`, `err_code` becomes 1 (device ID) on the next cycle.
- R3: The two words after the device ID, or after a payload CRC, form a header. The block number is bits 31:24 of the first word. The length is bits 23:0 of the second word and counts payload words. When the length is nonzero, the next word must equal the header CRC of those two words. Otherwise `err_code` becomes 2.
- R4: Every CRC is the Ethernet CRC-32: reflected polynomial EDB88320h, register preset to all ones, each word fed from its lowest byte to its highest with bit 0 of each byte first, and the result complemented.
- R5: Each payload word makes `wr_valid` high for exactly one cycle, on the cycle after it is accepted. In that cycle `wr_word` carries the word and `wr_blk_id` carries its header's block number.
- R6: The word after the last payload word must equal the CRC of the block's payload words. Otherwise `err_code` becomes 3.
- R7: A header whose length is 0 is followed directly by the global CRC, with no header CRC. The global CRC covers all earlier words of the load, starting at the device ID. A mismatch sets `err_code` to 4.
- R8: A matching global CRC sets `cfg_done` to 1 on the next cycle with `err_code` 0. The flag holds until the next start word.
- R9: After a failure, and after completion, words without `in_start` leave `err_code` and `cfg_done` unchanged and produce no `wr_valid`.
- R10: Cycles with `in_valid` low have no effect, so a load may be split into bursts separated by idle cycles.
- R11: A start word arriving in the middle of a load abandons the partial load and begins a new one.
- R12: A load with no configuration blocks is valid: device ID, terminating header and global CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_word` is present this cycle |
| in_start | input | 1 | Present word is the first word of a load |
| in_word | input | 32 | Configuration word |
| cfg_done | output | 1 | Whole load verified |
| err_code | output | 3 | 0 none, 1 device ID, 2 header CRC, 3 payload CRC, 4 global CRC |
| wr_valid | output | 1 | Payload word strobe |
| wr_blk_id | output | 8 | Block number of the strobed word |
| wr_word | output | 32 | Strobed payload word |

## Verification
The hardest cases to reach from the ports are a single corrupted word deep in an otherwise well-formed load, and a terminating length word whose unused top byte is damaged while its length stays zero. Only the global check can catch that second case. To reach these cases, the bench builds each load with every CRC computed correctly. It then flips bit 31 of one word at a time, covering every position. For each flip it works out which check must fail, and on which word, from the word's role in the load. It also confirms that payload strobes stop at that word.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_DEVID   = 3'd1,
    ERR_HDR_CRC = 3'd2,
    ERR_DAT_CRC = 3'd3,
    ERR_GLB_CRC = 3'd4
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR_ID,
    ST_HDR_LEN,
    ST_HDR_CRC,
    ST_DATA,
    ST_DAT_CRC,
    ST_GLB_CRC,
    ST_DONE,
    ST_FAIL
  } st_e;

  // Reflected CRC-32 over one word, bit 0 first (lowest byte first).
  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++) begin
      r = (r >> 1) ^ (((r[0] ^ w[i]) == 1'b1) ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgchk_crc32.sv
module cfgchk_crc32
  import cfgchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        clr,
  input  logic [31:0] word,
  output logic [31:0] fcs
);

  logic [31:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= CRC_INIT;
    end else if (en) begin
      acc_q <= crc32_word(clr ? CRC_INIT : acc_q, word);
    end else if (clr) begin
      acc_q <= CRC_INIT;
    end
  end

  assign fcs = ~acc_q;

endmodule

// File: rtl/cfgchk_lenctr.sv
module cfgchk_lenctr #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dec,
  input  logic [LEN_W-1:0] len_val,
  output logic             last
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= len_val;
    end else if (dec) begin
      rem_q <= rem_q - ONE;
    end
  end

  assign last = (rem_q == ONE);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> (rem_q != '0)); // R6

endmodule

// File: rtl/cfgchk_seq.sv
module cfgchk_seq
  import cfgchk_pkg::*;
#(
  parameter int          LEN_W  = 24,
  parameter int          ID_W   = 8,
  parameter logic [31:0] DEV_ID = 32'h5A5A_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [31:0]      in_word,
  input  logic [31:0]      fcs_sec,
  input  logic [31:0]      fcs_glb,
  input  logic             len_last,
  output logic             sec_en,
  output logic             sec_clr,
  output logic             glb_en,
  output logic             glb_clr,
  output logic             len_load,
  output logic             len_dec,
  output logic             cfg_done,
  output err_e             err_code,
  output logic             wr_valid,
  output logic [ID_W-1:0]  wr_blk_id,
  output logic [31:0]      wr_word
);

  st_e             st_q;
  err_e            err_q;
  logic            done_q;
  logic            wrv_q;
  logic [ID_W-1:0] blk_q;
  logic [ID_W-1:0] wblk_q;
  logic [31:0]     wword_q;
  logic            active;
  logic            step;
  logic            len_zero;

  assign active   = (st_q != ST_IDLE) && (st_q != ST_DONE) && (st_q != ST_FAIL);
  assign step     = in_valid && !in_start && active;
  assign len_zero = (in_word[LEN_W-1:0] == '0);

  always_comb begin
    glb_clr  = in_valid && in_start;
    glb_en   = glb_clr || step;
    sec_clr  = glb_clr || (step && ((st_q == ST_HDR_CRC) || (st_q == ST_DAT_CRC)));
    sec_en   = step && ((st_q == ST_HDR_ID) || (st_q == ST_HDR_LEN) || (st_q == ST_DATA));
    len_load = step && (st_q == ST_HDR_LEN) && !len_zero;
    len_dec  = step && (st_q == ST_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      err_q   <= ERR_NONE;
      done_q  <= 1'b0;
      wrv_q   <= 1'b0;
      blk_q   <= '0;
      wblk_q  <= '0;
      wword_q <= '0;
    end else begin
      wrv_q <= 1'b0;
      if (in_valid && in_start) begin
        done_q <= 1'b0;
        if (in_word == DEV_ID) begin
          st_q  <= ST_HDR_ID;
          err_q <= ERR_NONE;
        end else begin
          st_q  <= ST_FAIL;
          err_q <= ERR_DEVID;
        end
      end else if (step) begin
        unique case (st_q)
          ST_HDR_ID: begin
            blk_q <= in_word[31 -: ID_W];
            st_q  <= ST_HDR_LEN;
          end
          ST_HDR_LEN: st_q <= len_zero ? ST_GLB_CRC : ST_HDR_CRC;
          ST_HDR_CRC: begin
            if (in_word == fcs_sec) st_q <= ST_DATA;
            else begin
              st_q  <= ST_FAIL;
              err_q <= ERR_HDR_CRC;
            end
          end
          ST_DATA: begin
            wrv_q   <= 1'b1;
            wblk_q  <= blk_q;
            wword_q <= in_word;
            if (len_last) st_q <= ST_DAT_CRC;
          end
          ST_DAT_CRC: begin
            if (in_word == fcs_sec) st_q <= ST_HDR_ID;
            else begin
              st_q  <= ST_FAIL;
              err_q <= ERR_DAT_CRC;
            end
          end
          ST_GLB_CRC: begin
            if (in_word == fcs_glb) begin
              st_q   <= ST_DONE;
              done_q <= 1'b1;
            end else begin
              st_q  <= ST_FAIL;
              err_q <= ERR_GLB_CRC;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cfg_done  = done_q;
  assign err_code  = err_q;
  assign wr_valid  = wrv_q;
  assign wr_blk_id = wblk_q;
  assign wr_word   = wword_q;

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> (err_code == ERR_NONE)); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && !(in_valid && in_start)) |=> cfg_done); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((err_code != ERR_NONE) && !(in_valid && in_start)) |=> $stable(err_code)); // R9

  AST_NO_WR_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    (err_code != ERR_NONE) |=> !wr_valid); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start) |=> !cfg_done); // R2

  AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wr_valid); // R10

endmodule

// File: rtl/cfgchk_top.sv
module cfgchk_top
  import cfgchk_pkg::*;
#(
  parameter int          LEN_W  = 24,
  parameter int          ID_W   = 8,
  parameter logic [31:0] DEV_ID = 32'h5A5A_0001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_start,
  input  logic [31:0]     in_word,
  output logic            cfg_done,
  output logic [2:0]      err_code,
  output logic            wr_valid,
  output logic [ID_W-1:0] wr_blk_id,
  output logic [31:0]     wr_word
);

  localparam int N_ACC = 2;  // 0: section CRC, 1: global CRC

  logic [N_ACC-1:0] acc_en;
  logic [N_ACC-1:0] acc_clr;
  logic [31:0]      acc_fcs [N_ACC];
  logic             len_load;
  logic             len_dec;
  logic             len_last;
  err_e             err_w;

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    cfgchk_crc32 u_crc (
      .clk  (clk),
      .rst  (rst),
      .en   (acc_en[g]),
      .clr  (acc_clr[g]),
      .word (in_word),
      .fcs  (acc_fcs[g])
    );
  end

  cfgchk_lenctr #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst     (rst),
    .load    (len_load),
    .dec     (len_dec),
    .len_val (in_word[LEN_W-1:0]),
    .last    (len_last)
  );

  cfgchk_seq #(.LEN_W(LEN_W), .ID_W(ID_W), .DEV_ID(DEV_ID)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_word   (in_word),
    .fcs_sec   (acc_fcs[0]),
    .fcs_glb   (acc_fcs[1]),
    .len_last  (len_last),
    .sec_en    (acc_en[0]),
    .sec_clr   (acc_clr[0]),
    .glb_en    (acc_en[1]),
    .glb_clr   (acc_clr[1]),
    .len_load  (len_load),
    .len_dec   (len_dec),
    .cfg_done  (cfg_done),
    .err_code  (err_w),
    .wr_valid  (wr_valid),
    .wr_blk_id (wr_blk_id),
    .wr_word   (wr_word)
  );

  assign err_code = err_w;

endmodule

// File: tb/sim_cfgchk_top.sv
module sim_cfgchk_top;

  localparam logic [31:0] DEVID = 32'h5A5A_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_start = 1'b0;
  logic [31:0] in_word = '0;
  logic        cfg_done;
  logic [2:0]  err_code;
  logic        wr_valid;
  logic [7:0]  wr_blk_id;
  logic [31:0] wr_word;

  int checks = 0;
  int errors = 0;

  logic [31:0] s       [0:63];
  logic        exp_wr  [0:63];
  logic [7:0]  exp_blk [0:63];
  int          det_idx [0:63];
  int          det_err [0:63];
  int          n = 0;

  always #5 clk = ~clk;

  cfgchk_top #(.DEV_ID(DEVID)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_word(in_word),
    .cfg_done(cfg_done), .err_code(err_code), .wr_valid(wr_valid),
    .wr_blk_id(wr_blk_id), .wr_word(wr_word)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Byte-wise Ethernet CRC over s[first .. first+cnt-1], lowest byte first (R4)
  function automatic logic [31:0] ref_crc(input int first, input int cnt);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = first; k < first + cnt; k++) begin
      for (int b = 0; b < 4; b++) begin
        c = c ^ {24'h0, s[k][8*b +: 8]};
        for (int t = 0; t < 8; t++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  task automatic build(input int nblk, input int lv);
    int p = 0;
    s[p] = DEVID; exp_wr[p] = 0; det_idx[p] = 0; det_err[p] = 1; p++;
    for (int b = 0; b < nblk; b++) begin
      int len = ((b + lv) % 4) + 1;
      int h = p;
      s[p]   = {8'h10 + 8'(b), 24'h00_0000 + 24'(b * 3)};
      s[p+1] = {8'h00, 24'(len)};
      s[p+2] = ref_crc(h, 2);
      for (int q = 0; q < 3; q++) begin
        exp_wr[p+q] = 0; det_idx[p+q] = h + 2; det_err[p+q] = 2;
      end
      p = p + 3;
      for (int q = 0; q < len; q++) begin
        s[p+q] = 32'h0123_4567 * (b + 1) + 32'h9E37_79B9 * q;
        exp_wr[p+q] = 1; exp_blk[p+q] = 8'h10 + 8'(b);
        det_idx[p+q] = p + len; det_err[p+q] = 3;
      end
      s[p+len] = ref_crc(p, len);
      exp_wr[p+len] = 0; det_idx[p+len] = p + len; det_err[p+len] = 3;
      p = p + len + 1;
    end
    s[p] = 32'hCAFE_0000; s[p+1] = 32'h0000_0000;
    s[p+2] = ref_crc(0, p + 2);
    for (int q = 0; q < 3; q++) begin
      exp_wr[p+q] = 0; det_idx[p+q] = p + 2; det_err[p+q] = 4;
    end
    n = p + 3;
  endtask

  // Drive words [0, upto); strobe expected only for payload words before 'detect'.
  task automatic send(input int upto, input int detect, input int gapmod);
    for (int i = 0; i < upto; i++) begin
      if (gapmod > 0 && (i % gapmod) == 1) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk(!wr_valid, "R10 idle no strobe", 32'(wr_valid), 0);
      end
      in_valid = 1'b1; in_start = (i == 0); in_word = s[i];
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0;
      if (exp_wr[i] && i < detect) begin
        chk(wr_valid && wr_word == s[i] && wr_blk_id == exp_blk[i], "R5 payload strobe",
            wr_word, s[i]);
      end else begin
        chk(!wr_valid, "R5 no strobe", 32'(wr_valid), 0);
      end
    end
  endtask

  task automatic stray(input logic [2:0] e, input logic d);
    for (int k = 0; k < 2; k++) begin
      in_valid = 1'b1; in_start = 1'b0; in_word = 32'hDEAD_0000 + 32'(k);
      @(negedge clk);
      in_valid = 1'b0;
      chk(err_code == e && cfg_done == d && !wr_valid, "R9 stray word ignored",
          {28'h0, cfg_done, err_code}, {28'h0, d, e});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_done == 0, "R1 reset done", 32'(cfg_done), 0);
    chk(err_code == 0, "R1 reset err", 32'(err_code), 0);
    chk(wr_valid == 0, "R1 reset strobe", 32'(wr_valid), 0);

    // Good loads: R3 R4 R5 R6 R7 R8 R10 R12
    for (int nb = 0; nb < 4; nb++) begin
      for (int lv = 0; lv < 4; lv++) begin
        build(nb, lv);
        send(n, 64, lv);
        chk(cfg_done == 1 && err_code == 0, "R8 good load done",
            {28'h0, cfg_done, err_code}, 32'h8);
        if (nb == 0) chk(cfg_done == 1, "R12 empty load", 32'(cfg_done), 1);
        stray(3'd0, 1'b1);
      end
    end

    // Start word clears done (R2)
    in_valid = 1'b1; in_start = 1'b1; in_word = DEVID;
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    chk(cfg_done == 0 && err_code == 0, "R2 start clears done", {28'h0, cfg_done, err_code}, 0);

    // Single-bit corruption at every position: R2 R3 R6 R7 R9
    for (int nb = 0; nb < 3; nb++) begin
      for (int pos = 0; pos < 64; pos++) begin
        build(nb, 1);
        if (pos < n) begin
          s[pos][31] = ~s[pos][31];
          send(det_idx[pos] + 1, det_idx[pos], 0);
          chk(err_code == 3'(det_err[pos]) && cfg_done == 0, "R3 R6 R7 error class",
              32'(err_code), 32'(det_err[pos]));
          send(n - det_idx[pos] - 1 > 0 ? 0 : 0, 0, 0);
          stray(3'(det_err[pos]), 1'b0);
        end
      end
    end

    // Mid-load restart (R11): abandon a partial load, then a full one
    build(2, 2);
    send(n / 2, 64, 0);
    send(n, 64, 3);
    chk(cfg_done == 1 && err_code == 0, "R11 restart mid load", {28'h0, cfg_done, err_code}, 32'h8);

    // Restart after failure (R2)
    build(1, 0);
    s[0] = ~DEVID;
    send(1, 0, 0);
    chk(err_code == 1, "R2 device ID mismatch", 32'(err_code), 1);
    s[0] = DEVID;
    send(n, 64, 0);
    chk(cfg_done == 1 && err_code == 0, "R2 reload after failure", {28'h0, cfg_done, err_code}, 32'h8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule